// File: doc/BRIEF.md
# Strobe-Select Asynchronous Memory Read Sequencer

This block performs word reads from an external asynchronous device such as an SRAM or a parallel flash. In this mode the chip select pin works as a strobe. A requester presents a word address and the index of the chip-select space to read. The sequencer then steps through a turnaround phase, a setup phase, a strobe phase and a hold phase. It drives the external address, one active-low chip select per space, output enable, and the write-side pins, which it holds inactive throughout.

Each space has its own timing and bus-width settings, given as flat configuration vectors. The device bus of a space may be 8, 16 or 32 bits wide. On a narrow bus, one 32-bit word read becomes two or four back-to-back external cycles at consecutive device addresses, and the pieces are packed into the word with the lowest address in the lowest lane.

The turnaround phase is skipped when the read follows a completed read to the same space. A request that is already waiting when the final hold phase ends is taken on that same edge, with no idle cycle between the two reads.

Top module: `strobe_rd_seq`

## Requirements
- R1: Only the chip select of the addressed space goes low, and only during strobe cycles, together with output enable. A strobe with configured value S lasts S+1 cycles per external access. All other chip selects stay high.
- R2: The write-enable pin `mem_we_n` and the direction pin `mem_rw` stay high at all times.
- R3: Some reads do not follow a completed read to the same space, for example the first read after reset or a read to a different space. Such a read spends max(T,1) cycles with `mem_addr_vld` low after acceptance, where T is the space's turnaround value. Setup follows.
- R4: A read to the same space as the last completed read enters setup in the cycle right after acceptance, with no turnaround cycle.
- R5: For each external access, `mem_addr_vld` is high for (U+1)+(S+1)+(H+1) cycles, where U, S and H are the setup, strobe and hold values. The strobe cycles always fall inside that window.
- R6: Width code 0 selects an 8-bit bus (4 accesses at device addresses 4A..4A+3). Code 1 selects a 16-bit bus (2 accesses at 2A, 2A+1). Codes 2 and 3 select a 32-bit bus (1 access at A). The address is stable during each strobe.
- R7: Data is sampled at the last strobe cycle of each access. Byte or halfword k of the word comes from access k, taken from the low lanes of `mem_dq`. `rd_valid` is high for exactly one cycle, the cycle after the final hold cycle, with the assembled word on `rd_data`.
- R8: Setup, strobe and hold values are captured when setup is entered from turnaround or from acceptance. Later changes to the configuration do not affect the remaining accesses of the same word.
- R9: A request held valid during a read is accepted in the final hold cycle. Its turnaround or setup starts in the very next cycle.
- R10: During reset, all chip selects, `mem_oe_n`, `mem_we_n` and `mem_rw` are high, `mem_addr_vld` and `rd_valid` are low, and `req_ready` is high. Reset also clears the record of the last completed read.
- R11: `req_ready` is high only while idle and in the final hold cycle of a word. During a read, it is high in exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | WADDR_W | Word address |
| req_space | input | SPACE_W | Chip-select space index |
| cfg_turn | input | NUM_SPACES*TA_W | Turnaround cycles per space |
| cfg_setup | input | NUM_SPACES*SETUP_W | Setup value per space (N+1 cycles) |
| cfg_strobe | input | NUM_SPACES*STROBE_W | Strobe value per space (N+1 cycles) |
| cfg_hold | input | NUM_SPACES*HOLD_W | Hold value per space (N+1 cycles) |
| cfg_width | input | NUM_SPACES*2 | Bus width code per space |
| mem_addr | output | WADDR_W+2 | External device address |
| mem_addr_vld | output | 1 | Address valid (setup, strobe, hold) |
| mem_cs_n | output | NUM_SPACES | Active-low chip select per space |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable, held high |
| mem_rw | output | 1 | Direction pin, held high (read) |
| mem_dq | input | 32 | External data bus |
| rd_valid | output | 1 | One-cycle read-complete pulse |
| rd_data | output | 32 | Assembled read word |

## Verification
A table of single reads covers the three bus widths and both encodings of the 32-bit width. It also covers zero and maximum phase values, addresses at the top of the range, and switches between spaces. Together these separate a missing or extra turnaround cycle, an off-by-one phase length, a wrong beat count or address step, and lane misplacement in the packed word. Directed pairs of overlapping requests show whether the pending request is taken at the final hold edge and which turnaround rule applies: same space, a different space with zero turnaround, or a different space with a nonzero one. A mid-word configuration change shows whether the timing is wrongly reloaded between accesses, and a reset between two same-space reads shows whether the last-read record is cleared.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  localparam logic [1:0] WID_8  = 2'd0;
  localparam logic [1:0] WID_16 = 2'd1;

  // index of the final external access for a given width code
  function automatic logic [1:0] last_beat_idx(input logic [1:0] wid);
    case (wid)
      WID_8:   return 2'd3;
      WID_16:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srs_cfg_mux.sv
module srs_cfg_mux #(
  parameter int NUM_SPACES = 4,
  parameter int SPACE_W    = 2,
  parameter int TA_W       = 4,
  parameter int SETUP_W    = 4,
  parameter int STROBE_W   = 6,
  parameter int HOLD_W     = 3
) (
  input  logic [SPACE_W-1:0]             sel,
  input  logic [NUM_SPACES*TA_W-1:0]     cfg_turn,
  input  logic [NUM_SPACES*SETUP_W-1:0]  cfg_setup,
  input  logic [NUM_SPACES*STROBE_W-1:0] cfg_strobe,
  input  logic [NUM_SPACES*HOLD_W-1:0]   cfg_hold,
  input  logic [NUM_SPACES*2-1:0]        cfg_width,
  output logic [TA_W-1:0]                ta_o,
  output logic [SETUP_W-1:0]             su_o,
  output logic [STROBE_W-1:0]            st_o,
  output logic [HOLD_W-1:0]              hd_o,
  output logic [1:0]                     wd_o
);

  logic [TA_W-1:0]     ta_arr [NUM_SPACES];
  logic [SETUP_W-1:0]  su_arr [NUM_SPACES];
  logic [STROBE_W-1:0] st_arr [NUM_SPACES];
  logic [HOLD_W-1:0]   hd_arr [NUM_SPACES];
  logic [1:0]          wd_arr [NUM_SPACES];

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_slice
    assign ta_arr[g] = cfg_turn[g*TA_W +: TA_W];
    assign su_arr[g] = cfg_setup[g*SETUP_W +: SETUP_W];
    assign st_arr[g] = cfg_strobe[g*STROBE_W +: STROBE_W];
    assign hd_arr[g] = cfg_hold[g*HOLD_W +: HOLD_W];
    assign wd_arr[g] = cfg_width[g*2 +: 2];
  end

  assign ta_o = ta_arr[sel];
  assign su_o = su_arr[sel];
  assign st_o = st_arr[sel];
  assign hd_o = hd_arr[sel];
  assign wd_o = wd_arr[sel];

endmodule

// File: rtl/srs_turn_track.sv
module srs_turn_track #(
  parameter int SPACE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_i,
  input  logic [SPACE_W-1:0] done_space_i,
  input  logic [SPACE_W-1:0] new_space_i,
  output logic               follow_o
);

  logic               prev_rd_q, prev_rd_d;
  logic [SPACE_W-1:0] prev_sp_q, prev_sp_d;

  always_comb begin
    prev_rd_d = prev_rd_q;
    prev_sp_d = prev_sp_q;
    if (done_i) begin
      prev_rd_d = 1'b1;
      prev_sp_d = done_space_i;
    end
  end

  // a word finishing on this edge counts as the preceding read
  always_comb begin
    if (done_i) follow_o = (done_space_i == new_space_i);
    else        follow_o = prev_rd_q && (prev_sp_q == new_space_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q <= 1'b0;
      prev_sp_q <= '0;
    end else if (done_i) begin
      prev_rd_q <= prev_rd_d;
      prev_sp_q <= prev_sp_d;
    end
  end

endmodule

// File: rtl/srs_packer.sv
module srs_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  width_i,
  input  logic [1:0]  beat_i,
  input  logic        cap_i,
  input  logic [31:0] bus_i,
  input  logic        done_i,
  output logic [31:0] word_o,
  output logic        valid_o
);

  logic [31:0] acc_q, acc_d;
  logic        vld_q;

  always_comb begin
    acc_d = acc_q;
    case (width_i)
      srs_pkg::WID_8:  acc_d[{beat_i, 3'b000} +: 8]     = bus_i[7:0];
      srs_pkg::WID_16: acc_d[{beat_i[0], 4'b0000} +: 16] = bus_i[15:0];
      default:         acc_d = bus_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (cap_i) acc_q <= acc_d;
      vld_q <= done_i;
    end
  end

  assign word_o  = acc_q;
  assign valid_o = vld_q;

endmodule

// File: rtl/strobe_rd_seq.sv
module strobe_rd_seq #(
  parameter int NUM_SPACES = 4,
  parameter int WADDR_W    = 22,
  parameter int TA_W       = 4,
  parameter int SETUP_W    = 4,
  parameter int STROBE_W   = 6,
  parameter int HOLD_W     = 3,
  localparam int SPACE_W   = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
  localparam int MADDR_W   = WADDR_W + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [WADDR_W-1:0]             req_addr,
  input  logic [SPACE_W-1:0]             req_space,
  input  logic [NUM_SPACES*TA_W-1:0]     cfg_turn,
  input  logic [NUM_SPACES*SETUP_W-1:0]  cfg_setup,
  input  logic [NUM_SPACES*STROBE_W-1:0] cfg_strobe,
  input  logic [NUM_SPACES*HOLD_W-1:0]   cfg_hold,
  input  logic [NUM_SPACES*2-1:0]        cfg_width,
  output logic [MADDR_W-1:0]             mem_addr,
  output logic                           mem_addr_vld,
  output logic [NUM_SPACES-1:0]          mem_cs_n,
  output logic                           mem_oe_n,
  output logic                           mem_we_n,
  output logic                           mem_rw,
  input  logic [31:0]                    mem_dq,
  output logic                           rd_valid,
  output logic [31:0]                    rd_data
);

  import srs_pkg::*;

  localparam int CNT_W = max2(max2(TA_W, SETUP_W), max2(STROBE_W, HOLD_W));

  phase_e              ph_q, ph_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [WADDR_W-1:0]  addr_q, addr_d;
  logic [SPACE_W-1:0]  sp_q, sp_d;
  logic [1:0]          wid_q, wid_d;
  logic [1:0]          beat_q, beat_d;
  logic [SETUP_W-1:0]  su_q, su_d;
  logic [STROBE_W-1:0] st_q, st_d;
  logic [HOLD_W-1:0]   hd_q, hd_d;

  logic [SPACE_W-1:0]  cfg_sel;
  logic [TA_W-1:0]     c_ta;
  logic [SETUP_W-1:0]  c_su;
  logic [STROBE_W-1:0] c_st;
  logic [HOLD_W-1:0]   c_hd;
  logic [1:0]          c_wd;

  logic phase_end, last_beat, final_end, accept, follow, load_tim, capture;

  assign phase_end = (cnt_q == '0);
  assign last_beat = (beat_q == last_beat_idx(wid_q));
  assign final_end = (ph_q == PH_HOLD) && phase_end && last_beat;
  assign req_ready = (ph_q == PH_IDLE) || final_end;
  assign accept    = req_valid && req_ready;
  assign capture   = (ph_q == PH_STROBE) && phase_end;
  assign cfg_sel   = accept ? req_space : sp_q;

  srs_cfg_mux #(
    .NUM_SPACES(NUM_SPACES), .SPACE_W(SPACE_W), .TA_W(TA_W),
    .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W)
  ) u_cfg (
    .sel(cfg_sel), .cfg_turn(cfg_turn), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_width(cfg_width),
    .ta_o(c_ta), .su_o(c_su), .st_o(c_st), .hd_o(c_hd), .wd_o(c_wd)
  );

  srs_turn_track #(.SPACE_W(SPACE_W)) u_turn (
    .clk(clk), .rst_n(rst_n), .done_i(final_end),
    .done_space_i(sp_q), .new_space_i(req_space), .follow_o(follow)
  );

  srs_packer u_pack (
    .clk(clk), .rst_n(rst_n), .width_i(wid_q), .beat_i(beat_q),
    .cap_i(capture), .bus_i(mem_dq), .done_i(final_end),
    .word_o(rd_data), .valid_o(rd_valid)
  );

  // next-state logic
  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    sp_d     = sp_q;
    wid_d    = wid_q;
    beat_d   = beat_q;
    su_d     = su_q;
    st_d     = st_q;
    hd_d     = hd_q;
    load_tim = 1'b0;
    case (ph_q)
      PH_TURN: begin
        if (phase_end) begin
          ph_d     = PH_SETUP;
          load_tim = 1'b1;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      PH_SETUP: begin
        if (phase_end) begin
          ph_d  = PH_STROBE;
          cnt_d = CNT_W'(st_q);
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      PH_STROBE: begin
        if (phase_end) begin
          ph_d  = PH_HOLD;
          cnt_d = CNT_W'(hd_q);
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      PH_HOLD: begin
        if (phase_end) begin
          if (!last_beat) begin
            ph_d   = PH_SETUP;
            cnt_d  = CNT_W'(su_q);
            beat_d = beat_q + 2'd1;
          end else ph_d = PH_IDLE;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      default: ;
    endcase
    if (accept) begin
      addr_d = req_addr;
      sp_d   = req_space;
      wid_d  = c_wd;
      beat_d = 2'd0;
      if (follow) begin
        ph_d     = PH_SETUP;
        load_tim = 1'b1;
      end else begin
        ph_d  = PH_TURN;
        cnt_d = (c_ta == '0) ? '0 : (CNT_W'(c_ta) - CNT_W'(1));
      end
    end
    if (load_tim) begin
      su_d  = c_su;
      st_d  = c_st;
      hd_d  = c_hd;
      cnt_d = CNT_W'(c_su);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      sp_q   <= '0;
      wid_q  <= '0;
      beat_q <= '0;
      su_q   <= '0;
      st_q   <= '0;
      hd_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      if (accept) begin
        addr_q <= addr_d;
        sp_q   <= sp_d;
        wid_q  <= wid_d;
      end
      if (load_tim) begin
        su_q <= su_d;
        st_q <= st_d;
        hd_q <= hd_d;
      end
    end
  end

  // pin drive
  logic [MADDR_W-1:0] ext_addr;
  always_comb begin
    case (wid_q)
      WID_8:   ext_addr = {addr_q, beat_q};
      WID_16:  ext_addr = {1'b0, addr_q, beat_q[0]};
      default: ext_addr = {2'b00, addr_q};
    endcase
  end

  assign mem_addr_vld = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
  assign mem_addr     = mem_addr_vld ? ext_addr : '0;
  assign mem_oe_n     = (ph_q != PH_STROBE);
  assign mem_we_n     = 1'b1;
  assign mem_rw       = 1'b1;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_cs
    assign mem_cs_n[g] = !((ph_q == PH_STROBE) && (sp_q == SPACE_W'(g)));
  end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int NUM_SPACES = 4,
  parameter int MADDR_W    = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic [MADDR_W-1:0]    mem_addr,
  input logic                  mem_addr_vld,
  input logic [NUM_SPACES-1:0] mem_cs_n,
  input logic                  mem_oe_n,
  input logic                  mem_we_n,
  input logic                  mem_rw,
  input logic                  rd_valid
);

  assert_cs_with_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1) |-> !mem_oe_n);

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ($countones(~mem_cs_n) == 1));

  assert_write_pins_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_n && mem_rw);

  assert_strobe_in_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_addr_vld);

  assert_addr_stable_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_valid_after_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_addr_vld && mem_oe_n));

  assert_no_ready_in_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !req_ready);

endmodule

bind strobe_rd_seq srs_checker #(
  .NUM_SPACES(NUM_SPACES),
  .MADDR_W(MADDR_W)
) u_srs_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_rw(mem_rw), .rd_valid(rd_valid)
);

// File: tb/test_strobe_rd_seq.sv
module test_strobe_rd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int AW = 22;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_space;
  logic [NS*4-1:0] cfg_turn, cfg_setup;
  logic [NS*6-1:0] cfg_strobe;
  logic [NS*3-1:0] cfg_hold;
  logic [NS*2-1:0] cfg_width;
  logic [AW+1:0] mem_addr;
  logic          mem_addr_vld, mem_oe_n, mem_we_n, mem_rw, rd_valid;
  logic [NS-1:0] mem_cs_n;
  logic [31:0]   mem_dq, rd_data;

  logic [3:0] ta_c [NS];
  logic [3:0] su_c [NS];
  logic [5:0] st_c [NS];
  logic [2:0] hd_c [NS];
  logic [1:0] wd_c [NS];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      cfg_turn[i*4 +: 4]   = ta_c[i];
      cfg_setup[i*4 +: 4]  = su_c[i];
      cfg_strobe[i*6 +: 6] = st_c[i];
      cfg_hold[i*3 +: 3]   = hd_c[i];
      cfg_width[i*2 +: 2]  = wd_c[i];
    end
  end

  function automatic logic [31:0] mem_fn(input logic [AW+1:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'h5A, a[7:0] + 8'h11, a[7:0] ^ 8'hC3};
  endfunction

  always_comb mem_dq = mem_fn(mem_addr);

  strobe_rd_seq i_strobe_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .cfg_turn(cfg_turn),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .cfg_width(cfg_width), .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_rw(mem_rw), .mem_dq(mem_dq), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  bit  have_prev = 1'b0;
  int  prev_sp = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW+1:0] exp_addr(input int wd, input logic [AW-1:0] a, input int k);
    if (wd == 0)      return {a, 2'(k)};
    else if (wd == 1) return {1'b0, a, 1'(k)};
    else              return {2'b00, a};
  endfunction

  function automatic logic [31:0] exp_word(input int wd, input logic [AW-1:0] a);
    logic [31:0] w, t;
    w = '0;
    if (wd == 0) begin
      for (int k = 0; k < 4; k++) begin t = mem_fn(exp_addr(0, a, k)); w[k*8 +: 8] = t[7:0]; end
    end else if (wd == 1) begin
      for (int k = 0; k < 2; k++) begin t = mem_fn(exp_addr(1, a, k)); w[k*16 +: 16] = t[15:0]; end
    end else w = mem_fn(exp_addr(2, a, 0));
    return w;
  endfunction

  task automatic set_cfg(input int sp, input int wd, input int ta, input int su,
                         input int st, input int hd);
    ta_c[sp] = 4'(ta); su_c[sp] = 4'(su); st_c[sp] = 6'(st);
    hd_c[sp] = 3'(hd); wd_c[sp] = 2'(wd);
  endtask

  task automatic check_reset_pins();
    chk(mem_cs_n == '1, "R10", "cs during reset", mem_cs_n, 4'hF);
    chk(mem_oe_n && mem_we_n && mem_rw, "R10", "oe/we/rw during reset",
        {mem_oe_n, mem_we_n, mem_rw}, 3'b111);
    chk(!mem_addr_vld && !rd_valid, "R10", "addr_vld/rd_valid during reset",
        {mem_addr_vld, rd_valid}, 2'b00);
    chk(req_ready, "R10", "ready during reset", req_ready, 1);
  endtask

  task automatic do_read(input int sp, input int wd, input int ta, input int su,
                         input int st, input int hd, input logic [AW-1:0] a,
                         input bit chg, input int new_st);
    int exp_ta, beats, pre, av, stb, nb, bad_addr, bad_pins, bad_cs, rdy, guard;
    bit seen_av, cs_prev, changed;
    logic [31:0] got;
    pre = 0; av = 0; stb = 0; nb = 0; bad_addr = 0; bad_pins = 0; bad_cs = 0;
    rdy = 0; guard = 0; seen_av = 0; cs_prev = 1; changed = 0;
    set_cfg(sp, wd, ta, su, st, hd);
    exp_ta = (have_prev && prev_sp == sp) ? 0 : ((ta == 0) ? 1 : ta);
    beats  = (wd == 0) ? 4 : ((wd == 1) ? 2 : 1);
    req_space = 2'(sp); req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_valid && guard < 4000) begin
      if (!mem_addr_vld && !seen_av) pre++;
      if (mem_addr_vld) begin seen_av = 1; av++; end
      if (req_ready) rdy++;
      if (!mem_cs_n[sp]) begin
        stb++;
        if (cs_prev) begin
          if (mem_addr !== exp_addr(wd, a, nb)) bad_addr++;
          nb++;
        end
      end
      if (chg && !changed && nb == 1 && mem_cs_n[sp]) begin
        st_c[sp] = 6'(new_st);
        changed = 1;
      end
      for (int i = 0; i < NS; i++) if (i != sp && !mem_cs_n[i]) bad_cs++;
      if (mem_cs_n[sp] != mem_oe_n) bad_cs++;
      if (!mem_we_n || !mem_rw) bad_pins++;
      cs_prev = mem_cs_n[sp];
      guard++;
      @(negedge clk);
    end
    got = rd_data;
    if (exp_ta == 0) chk(pre == 0, "R4", "same-space read turnaround cycles", pre, 0);
    else             chk(pre == exp_ta, "R3", "turnaround cycles", pre, exp_ta);
    if (chg) chk(stb == beats*(st+1), "R8", "strobe cycles after mid-word cfg change", stb, beats*(st+1));
    else     chk(stb == beats*(st+1), "R1", "strobe cycles", stb, beats*(st+1));
    chk(av == beats*(su+st+hd+3), "R5", "address-valid cycles", av, beats*(su+st+hd+3));
    chk(nb == beats, "R6", "external access count", nb, beats);
    chk(bad_addr == 0, "R6", "external address mismatches", bad_addr, 0);
    chk(bad_cs == 0, "R1", "chip select misuse cycles", bad_cs, 0);
    chk(bad_pins == 0, "R2", "we/rw low cycles", bad_pins, 0);
    chk(rdy == 1, "R11", "ready cycles while busy", rdy, 1);
    chk(rd_valid && got == exp_word(wd, a), "R7", "read word", got, exp_word(wd, a));
    @(negedge clk);
    chk(!rd_valid, "R7", "rd_valid second cycle", rd_valid, 0);
    if (chg) st_c[sp] = 6'(st);
    have_prev = 1; prev_sp = sp;
  endtask

  task automatic do_pair(input int spa, input logic [AW-1:0] aa,
                         input int spb, input logic [AW-1:0] ab);
    int gap, nrv, exp_gap, guard;
    bit seen_av, rdy_seen;
    logic [31:0] got_a, got_b;
    gap = 0; nrv = 0; guard = 0; seen_av = 0; rdy_seen = 0; got_a = '0; got_b = '0;
    exp_gap = (spa == spb) ? 0 : ((ta_c[spb] == 0) ? 1 : int'(ta_c[spb]));
    req_space = 2'(spa); req_addr = aa; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_space = 2'(spb); req_addr = ab;
    while (nrv < 2 && guard < 4000) begin
      if (rdy_seen) req_valid = 1'b0;
      rdy_seen = req_valid && req_ready;
      if (rd_valid) begin
        nrv++;
        if (nrv == 1) got_a = rd_data; else got_b = rd_data;
      end
      if (nrv < 2) begin
        if (seen_av && !mem_addr_vld) gap++;
        if (mem_addr_vld) seen_av = 1;
        guard++;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    chk(gap == exp_gap, (spa == spb) ? "R4" : "R9", "gap between overlapped reads", gap, exp_gap);
    chk(got_a == exp_word(wd_c[spa], aa), "R7", "first word of pair", got_a, exp_word(wd_c[spa], aa));
    chk(got_b == exp_word(wd_c[spb], ab), "R9", "pending word of pair", got_b, exp_word(wd_c[spb], ab));
    @(negedge clk);
    have_prev = 1; prev_sp = spb;
  endtask

  typedef struct packed {
    logic [1:0]    sp;
    logic [1:0]    wd;
    logic [3:0]    ta;
    logic [3:0]    su;
    logic [5:0]    st;
    logic [2:0]    hd;
    logic [AW-1:0] a;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd2, 4'd2,  4'd0,  6'd0,  3'd0, 22'h000010},
    '{2'd0, 2'd2, 4'd5,  4'd1,  6'd2,  3'd1, 22'h3FFFFF},
    '{2'd1, 2'd0, 4'd0,  4'd0,  6'd1,  3'd0, 22'h000123},
    '{2'd1, 2'd1, 4'd3,  4'd2,  6'd0,  3'd2, 22'h2ABCDE},
    '{2'd2, 2'd1, 4'd3,  4'd0,  6'd3,  3'd0, 22'h000001},
    '{2'd3, 2'd0, 4'd1,  4'd3,  6'd2,  3'd1, 22'h3FFFFF},
    '{2'd2, 2'd3, 4'd4,  4'd0,  6'd0,  3'd7, 22'h155555},
    '{2'd0, 2'd0, 4'd15, 4'd15, 6'd63, 3'd7, 22'h00000F}
  };

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog all: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_space = '0;
    for (int i = 0; i < NS; i++) set_cfg(i, 2, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    check_reset_pins();
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++)
      do_read(int'(VECS[i].sp), int'(VECS[i].wd), int'(VECS[i].ta), int'(VECS[i].su),
              int'(VECS[i].st), int'(VECS[i].hd), VECS[i].a, 1'b0, 0);

    // R8: strobe value raised after the first access must not stretch later ones
    do_read(1, 0, 2, 1, 1, 0, 22'h000400, 1'b1, 9);

    // R9 / R4: overlapping requests
    set_cfg(2, 1, 5, 1, 1, 0);
    set_cfg(3, 0, 0, 0, 2, 1);
    set_cfg(0, 2, 3, 2, 0, 0);
    do_pair(2, 22'h000222, 2, 22'h000223);
    do_pair(2, 22'h000010, 3, 22'h0000AB);
    do_pair(3, 22'h000077, 0, 22'h1FFFF0);

    // R10: reset clears the last-read record
    do_read(0, 2, 3, 0, 0, 0, 22'h000005, 1'b0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_pins();
    rst_n = 1'b1;
    have_prev = 1'b0;
    @(negedge clk);
    do_read(0, 2, 3, 0, 0, 0, 22'h000006, 1'b0, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule